// File: doc/BRIEF.md
# Masked Two-Lane Blend Execute Unit

This unit executes one variable-blend instruction on 128-bit operands that are split into two 64-bit lanes. It decodes the prefix flags, the three opcode bytes and the mode and register fields of the operand-addressing byte. It checks the control and feature bits that gate the instruction. When the source is in memory, it also checks the effective address. It then does one of two things: it returns a blended result with a write enable for the destination register, or it reports a single fault code.

Each lane's select bit is the top bit of the matching lane of an implicit mask register. It is never taken from the addressing byte. A selected lane takes the source lane. An unselected lane keeps the destination's old value. The copy is purely bitwise, with no floating-point rounding, NaN handling or exceptions. The unit does not fetch instructions, access memory, translate addresses or hold the register file. The caller supplies the register and memory operand values and stores the result.

Top module: `vblend_exec`

## Requirements
- R1: The instruction is accepted only when `pfx_opsz` is 1 and `op_bytes` equals 24'h0F3815 (first byte in bits 23:16). Anything else raises invalid-opcode (fault code 1).
- R2: Lane k of `result` (bits 64k+63:64k) equals lane k of the source when `mask_reg` bit 64k+63 is 1, and lane k of `dst_in` otherwise. No other mask bit has any effect. `wr_idx` equals `modrm_reg`.
- R3: When `modrm_mod` is 2'b11, the source is `src_reg`. For any other value it is `src_mem`, and the address checks of R7 to R9 apply.
- R4: Invalid-opcode is raised when `ctl_emul` is 1, when `ctl_fxsave_os` is 0, or when `feat_blend` is 0.
- R5: Invalid-opcode is raised when `pfx_lock`, `pfx_rep` or `pfx_repne` is 1.
- R6: Device-not-available (fault code 2) is raised when `ctl_task_sw` is 1.
- R7: In any mode, a memory operand whose address has any of bits 3:0 set raises general-protection (fault code 4). The register form ignores `ea`.
- R8: In 64-bit mode (`cpu_mode` 2), a memory address whose bits 63:47 are not all equal raises stack-fault (fault code 3) when `ea_stack` is 1, and general-protection otherwise.
- R9: In real-address mode (`cpu_mode` 0), a memory operand raises general-protection when `ea`+15 exceeds 16'hFFFF. Protected mode (`cpu_mode` 1) has no such limit.
- R10: Only the highest-ranked fault is reported. The ranking is invalid-opcode, then device-not-available, then stack-fault, then general-protection.
- R11: Every completed instruction gives exactly one outcome. A fault holds `wr_en` low. A write reports fault code 0.
- R12: Outputs appear one clock after an `in_valid` pulse, with a one-cycle `out_valid` pulse. In a cycle without `out_valid`, `wr_en` is 0 and the fault code is 0.
- R13: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle issue strobe |
| pfx_opsz | input | 1 | Operand-size prefix (66h) present |
| pfx_lock | input | 1 | Lock prefix present |
| pfx_rep | input | 1 | F3h prefix present |
| pfx_repne | input | 1 | F2h prefix present |
| op_bytes | input | 24 | Opcode bytes, first byte in bits 23:16 |
| modrm_mod | input | 2 | Addressing-mode field |
| modrm_reg | input | 3 | Destination register index |
| cpu_mode | input | 2 | 0 real, 1 protected/compatibility, 2 64-bit |
| ctl_emul | input | 1 | Emulation control bit |
| ctl_task_sw | input | 1 | Task-switched control bit |
| ctl_fxsave_os | input | 1 | OS extended-state support bit |
| feat_blend | input | 1 | Feature flag for this instruction |
| dst_in | input | 128 | Current destination value |
| src_reg | input | 128 | Register source value |
| src_mem | input | 128 | Loaded memory source value |
| mask_reg | input | 128 | Implicit mask register |
| ea | input | 64 | Memory operand effective address |
| ea_stack | input | 1 | Address uses the stack segment |
| out_valid | output | 1 | Outcome strobe |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | 3 | Destination register index |
| result | output | 128 | Blended value |
| fault_code | output | 3 | 0 none, 1 invalid-opcode, 2 device-not-available, 3 stack-fault, 4 general-protection |

## Verification
The assertions assume that `in_valid` is a clean single-cycle strobe and that all operand and control inputs are stable across the issue edge. The lane-keep property compares against the inputs one cycle back, so it depends on this. The stimulus follows that rule. Every scenario sets all inputs at a falling edge, raises `in_valid` for exactly one cycle, and lowers it before the outcome is sampled. This keeps each issue separate from the next.

// File: rtl/vblend_pkg.sv
package vblend_pkg;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_NM   = 3'd2,
        FLT_SS   = 3'd3,
        FLT_GP   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_LONG = 2'd2
    } mode_e;

    localparam logic [1:0] MOD_REGISTER = 2'b11;

endpackage

// File: rtl/vblend_decode.sv
module vblend_decode #(
    parameter logic [23:0] OPCODE = 24'h0F3815
) (
    input  logic        pfx_opsz,
    input  logic        pfx_lock,
    input  logic        pfx_rep,
    input  logic        pfx_repne,
    input  logic [23:0] op_bytes,
    input  logic        ctl_emul,
    input  logic        ctl_task_sw,
    input  logic        ctl_fxsave_os,
    input  logic        feat_blend,
    output logic        ud,
    output logic        nm
);
    logic bad_encoding;
    logic bad_prefix;
    logic bad_enable;

    always_comb begin
        bad_encoding = !pfx_opsz || (op_bytes != OPCODE);
        bad_prefix   = pfx_lock || pfx_rep || pfx_repne;
        bad_enable   = ctl_emul || !ctl_fxsave_os || !feat_blend;
        ud           = bad_encoding || bad_prefix || bad_enable;
        nm           = ctl_task_sw;
    end
endmodule

// File: rtl/vblend_addrchk.sv
module vblend_addrchk
    import vblend_pkg::*;
#(
    parameter int          ADDR_W      = 64,
    parameter int          VA_BITS     = 48,
    parameter int          ALIGN_BYTES = 16,
    parameter logic [16:0] REAL_TOP    = 17'h0FFFF
) (
    input  logic              mem_form,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] ea,
    input  logic              ea_stack,
    output logic              ss_flt,
    output logic              gp_flt
);
    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

    logic              canonical;
    logic              misaligned;
    logic              real_over;
    logic [ADDR_W:0]   last_byte;

    always_comb begin
        canonical  = (&ea[ADDR_W-1:VA_BITS-1]) || !(|ea[ADDR_W-1:VA_BITS-1]);
        misaligned = |ea[ALIGN_LSB-1:0];
        last_byte  = {1'b0, ea} + (ADDR_W+1)'(ALIGN_BYTES - 1);
        real_over  = last_byte > (ADDR_W+1)'(REAL_TOP);
        ss_flt     = mem_form && (mode == MODE_LONG) && !canonical && ea_stack;
        gp_flt     = mem_form && (misaligned
                                  || ((mode == MODE_LONG) && !canonical && !ea_stack)
                                  || ((mode == MODE_REAL) && real_over));
    end
endmodule

// File: rtl/vblend_lanes.sv
module vblend_lanes #(
    parameter int LANE_W = 64,
    parameter int LANES  = 2
) (
    input  logic [LANE_W*LANES-1:0] dst,
    input  logic [LANE_W*LANES-1:0] src,
    input  logic [LANE_W*LANES-1:0] mask,
    output logic [LANE_W*LANES-1:0] res
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int LO = k * LANE_W;
        assign res[LO +: LANE_W] = mask[LO + LANE_W - 1] ? src[LO +: LANE_W]
                                                         : dst[LO +: LANE_W];
    end
endmodule

// File: rtl/vblend_exec.sv
module vblend_exec
    import vblend_pkg::*;
#(
    parameter int LANE_W  = 64,
    parameter int LANES   = 2,
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    pfx_opsz,
    input  logic                    pfx_lock,
    input  logic                    pfx_rep,
    input  logic                    pfx_repne,
    input  logic [23:0]             op_bytes,
    input  logic [1:0]              modrm_mod,
    input  logic [2:0]              modrm_reg,
    input  logic [1:0]              cpu_mode,
    input  logic                    ctl_emul,
    input  logic                    ctl_task_sw,
    input  logic                    ctl_fxsave_os,
    input  logic                    feat_blend,
    input  logic [LANE_W*LANES-1:0] dst_in,
    input  logic [LANE_W*LANES-1:0] src_reg,
    input  logic [LANE_W*LANES-1:0] src_mem,
    input  logic [LANE_W*LANES-1:0] mask_reg,
    input  logic [ADDR_W-1:0]       ea,
    input  logic                    ea_stack,
    output logic                    out_valid,
    output logic                    wr_en,
    output logic [2:0]              wr_idx,
    output logic [LANE_W*LANES-1:0] result,
    output logic [2:0]              fault_code
);
    localparam int DATA_W = LANE_W * LANES;

    typedef struct packed {
        logic              valid;
        logic              wr_en;
        logic [2:0]        idx;
        logic [DATA_W-1:0] data;
        fault_e            fault;
    } out_t;

    out_t              st_d, st_q;
    logic              ud, nm, ss_flt, gp_flt;
    logic              mem_form;
    logic [DATA_W-1:0] src_sel;
    logic [DATA_W-1:0] blended;

    assign mem_form = (modrm_mod != MOD_REGISTER);
    assign src_sel  = mem_form ? src_mem : src_reg;

    vblend_decode i_decode (
        .pfx_opsz      (pfx_opsz),
        .pfx_lock      (pfx_lock),
        .pfx_rep       (pfx_rep),
        .pfx_repne     (pfx_repne),
        .op_bytes      (op_bytes),
        .ctl_emul      (ctl_emul),
        .ctl_task_sw   (ctl_task_sw),
        .ctl_fxsave_os (ctl_fxsave_os),
        .feat_blend    (feat_blend),
        .ud            (ud),
        .nm            (nm)
    );

    vblend_addrchk #(
        .ADDR_W  (ADDR_W),
        .VA_BITS (VA_BITS)
    ) i_addrchk (
        .mem_form (mem_form),
        .mode     (mode_e'(cpu_mode)),
        .ea       (ea),
        .ea_stack (ea_stack),
        .ss_flt   (ss_flt),
        .gp_flt   (gp_flt)
    );

    vblend_lanes #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) i_lanes (
        .dst  (dst_in),
        .src  (src_sel),
        .mask (mask_reg),
        .res  (blended)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = in_valid;
        if (in_valid) begin
            if (ud) begin
                st_d.fault = FLT_UD;
            end else if (nm) begin
                st_d.fault = FLT_NM;
            end else if (ss_flt) begin
                st_d.fault = FLT_SS;
            end else if (gp_flt) begin
                st_d.fault = FLT_GP;
            end else begin
                st_d.wr_en = 1'b1;
                st_d.idx   = modrm_reg;
                st_d.data  = blended;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign wr_en      = st_q.wr_en;
    assign wr_idx     = st_q.idx;
    assign result     = st_q.data;
    assign fault_code = st_q.fault;
endmodule

// File: rtl/vblend_exec_chk.sv
module vblend_exec_chk #(
    parameter int LANE_W = 64,
    parameter int LANES  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    pfx_lock,
    input logic [LANE_W*LANES-1:0] mask_reg,
    input logic [LANE_W*LANES-1:0] dst_in,
    input logic                    out_valid,
    input logic                    wr_en,
    input logic [2:0]              fault_code,
    input logic [LANE_W*LANES-1:0] result
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (wr_en != (fault_code != 3'd0))); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && fault_code == 3'd0)); // R12

    AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R12

    AST_LOCK_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pfx_lock) |=> (fault_code == 3'd1)); // R5

    AST_LANE0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_reg[LANE_W-1])
        |=> (!wr_en || result[LANE_W-1:0] == $past(dst_in[LANE_W-1:0]))); // R2
endmodule

bind vblend_exec vblend_exec_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .pfx_lock   (pfx_lock),
    .mask_reg   (mask_reg),
    .dst_in     (dst_in),
    .out_valid  (out_valid),
    .wr_en      (wr_en),
    .fault_code (fault_code),
    .result     (result)
);

// File: tb/test_vblend_exec.sv
`timescale 1ns/1ps
module test_vblend_exec;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         pfx_opsz, pfx_lock, pfx_rep, pfx_repne;
    logic [23:0]  op_bytes;
    logic [1:0]   modrm_mod;
    logic [2:0]   modrm_reg;
    logic [1:0]   cpu_mode;
    logic         ctl_emul, ctl_task_sw, ctl_fxsave_os, feat_blend;
    logic [127:0] dst_in, src_reg, src_mem, mask_reg;
    logic [63:0]  ea;
    logic         ea_stack;
    logic         out_valid, wr_en;
    logic [2:0]   wr_idx, fault_code;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] D0 = 64'hD0D0_0000_1111_2222;
    localparam logic [63:0] D1 = 64'hD1D1_3333_4444_5555;
    localparam logic [63:0] S0 = 64'h5050_AAAA_BBBB_CCCC;
    localparam logic [63:0] S1 = 64'h5151_DDDD_EEEE_FFFF;
    localparam logic [63:0] M0 = 64'h3E3E_1212_3434_5656;
    localparam logic [63:0] M1 = 64'h3F3F_7878_9A9A_BCBC;

    always #2 clk = ~clk;

    vblend_exec i_vblend_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .pfx_opsz(pfx_opsz), .pfx_lock(pfx_lock), .pfx_rep(pfx_rep), .pfx_repne(pfx_repne),
        .op_bytes(op_bytes), .modrm_mod(modrm_mod), .modrm_reg(modrm_reg),
        .cpu_mode(cpu_mode), .ctl_emul(ctl_emul), .ctl_task_sw(ctl_task_sw),
        .ctl_fxsave_os(ctl_fxsave_os), .feat_blend(feat_blend),
        .dst_in(dst_in), .src_reg(src_reg), .src_mem(src_mem), .mask_reg(mask_reg),
        .ea(ea), .ea_stack(ea_stack),
        .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx),
        .result(result), .fault_code(fault_code)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic legal();
        pfx_opsz = 1'b1; pfx_lock = 1'b0; pfx_rep = 1'b0; pfx_repne = 1'b0;
        op_bytes = 24'h0F3815; modrm_mod = 2'b11; modrm_reg = 3'd5;
        cpu_mode = 2'd1; ctl_emul = 1'b0; ctl_task_sw = 1'b0;
        ctl_fxsave_os = 1'b1; feat_blend = 1'b1;
        dst_in = {D1, D0}; src_reg = {S1, S0}; src_mem = {M1, M0};
        mask_reg = '0; ea = 64'h1000; ea_stack = 1'b0;
    endtask

    task automatic fire();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_ok(input string tag, input logic [127:0] exp);
        chk({tag, " out_valid"}, 128'(out_valid), 128'd1);
        chk({tag, " wr_en"}, 128'(wr_en), 128'd1);
        chk({tag, " fault"}, 128'(fault_code), 128'd0);
        chk({tag, " result"}, result, exp);
    endtask

    task automatic expect_flt(input string tag, input logic [2:0] code);
        chk({tag, " out_valid"}, 128'(out_valid), 128'd1);
        chk({tag, " fault"}, 128'(fault_code), 128'(code));
        chk({tag, " R11 wr_en low"}, 128'(wr_en), 128'd0);
    endtask

    task automatic t_reset();
        chk("R13 out_valid", 128'(out_valid), 128'd0);
        chk("R13 wr_en", 128'(wr_en), 128'd0);
        chk("R13 fault", 128'(fault_code), 128'd0);
        chk("R13 result", result, 128'd0);
    endtask

    task automatic t_blend();
        legal(); mask_reg = '0; fire();
        expect_ok("R2 mask none", {D1, D0});
        chk("R2 wr_idx", 128'(wr_idx), 128'd5);
        legal(); mask_reg = {64'h0, 64'h8000_0000_0000_0000}; fire();
        expect_ok("R2 lane0 only", {D1, S0});
        legal(); mask_reg = {64'h8000_0000_0000_0000, 64'h0}; modrm_reg = 3'd2; fire();
        expect_ok("R2 lane1 only", {S1, D0});
        chk("R2 wr_idx 2", 128'(wr_idx), 128'd2);
        legal(); mask_reg = {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF}; fire();
        expect_ok("R2 both", {S1, S0});
        legal(); mask_reg = {64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF}; fire();
        expect_ok("R2 low bits ignored", {D1, D0});
    endtask

    task automatic t_source();
        legal(); modrm_mod = 2'b00; ea = 64'h2000; mask_reg = {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000}; fire();
        expect_ok("R3 memory source", {M1, M0});
        legal(); modrm_mod = 2'b10; ea = 64'h2000; mask_reg = {64'h0, 64'h8000_0000_0000_0000}; fire();
        expect_ok("R3 memory source mod2", {D1, M0});
    endtask

    task automatic t_decode();
        legal(); pfx_opsz = 1'b0; fire(); expect_flt("R1 no 66h", 3'd1);
        legal(); op_bytes = 24'h0F3814; fire(); expect_flt("R1 wrong opcode", 3'd1);
        legal(); op_bytes = 24'h0F3A15; fire(); expect_flt("R1 wrong map", 3'd1);
    endtask

    task automatic t_control();
        legal(); ctl_emul = 1'b1; fire(); expect_flt("R4 emulation", 3'd1);
        legal(); ctl_fxsave_os = 1'b0; fire(); expect_flt("R4 os support", 3'd1);
        legal(); feat_blend = 1'b0; fire(); expect_flt("R4 feature", 3'd1);
    endtask

    task automatic t_prefix();
        legal(); pfx_lock = 1'b1; fire(); expect_flt("R5 lock", 3'd1);
        legal(); pfx_rep = 1'b1; fire(); expect_flt("R5 rep", 3'd1);
        legal(); pfx_repne = 1'b1; fire(); expect_flt("R5 repne", 3'd1);
    endtask

    task automatic t_nm();
        legal(); ctl_task_sw = 1'b1; fire(); expect_flt("R6 task switched", 3'd2);
        legal(); ctl_task_sw = 1'b1; pfx_lock = 1'b1; fire(); expect_flt("R10 UD over NM", 3'd1);
        legal(); ctl_task_sw = 1'b1; modrm_mod = 2'b00; ea = 64'h1004; fire();
        expect_flt("R10 NM over GP", 3'd2);
    endtask

    task automatic t_align();
        legal(); modrm_mod = 2'b01; ea = 64'h1008; fire(); expect_flt("R7 misaligned prot", 3'd4);
        legal(); modrm_mod = 2'b00; ea = 64'h1001; cpu_mode = 2'd2; fire(); expect_flt("R7 misaligned long", 3'd4);
        legal(); modrm_mod = 2'b11; ea = 64'h1003; mask_reg = {64'h8000_0000_0000_0000, 64'h0}; fire();
        expect_ok("R7 register form ignores ea", {S1, D0});
    endtask

    task automatic t_long();
        legal(); cpu_mode = 2'd2; modrm_mod = 2'b00; ea = 64'h0000_8000_0000_0000; ea_stack = 1'b1; fire();
        expect_flt("R8 stack noncanonical", 3'd3);
        legal(); cpu_mode = 2'd2; modrm_mod = 2'b00; ea = 64'h0000_8000_0000_0000; fire();
        expect_flt("R8 data noncanonical", 3'd4);
        legal(); cpu_mode = 2'd2; modrm_mod = 2'b00; ea = 64'hFFFF_8000_0000_0000; ea_stack = 1'b1; fire();
        expect_ok("R8 canonical high", {D1, D0});
        legal(); cpu_mode = 2'd2; modrm_mod = 2'b00; ea = 64'h0000_8000_0000_0008; ea_stack = 1'b1; fire();
        expect_flt("R10 SS over GP", 3'd3);
        legal(); cpu_mode = 2'd1; modrm_mod = 2'b00; ea = 64'h0000_8000_0000_0000; ea_stack = 1'b1; fire();
        expect_ok("R8 not checked in protected", {D1, D0});
    endtask

    task automatic t_real();
        legal(); cpu_mode = 2'd0; modrm_mod = 2'b00; ea = 64'hFFF0; fire();
        expect_ok("R9 last fitting operand", {D1, D0});
        legal(); cpu_mode = 2'd0; modrm_mod = 2'b00; ea = 64'h1_0000; fire();
        expect_flt("R9 beyond limit", 3'd4);
        legal(); cpu_mode = 2'd1; modrm_mod = 2'b00; ea = 64'h1_0000; fire();
        expect_ok("R9 no limit in protected", {D1, D0});
    endtask

    task automatic t_idle();
        legal(); fire();
        @(negedge clk);
        chk("R12 pulse ends", 128'(out_valid), 128'd0);
        chk("R12 idle wr_en", 128'(wr_en), 128'd0);
        legal(); pfx_lock = 1'b1;
        @(negedge clk);
        chk("R12 no issue no fault", 128'(fault_code), 128'd0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0;
        legal();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_blend();
        t_source();
        t_decode();
        t_control();
        t_prefix();
        t_nm();
        t_align();
        t_long();
        t_real();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule